// File: doc/BRIEF.md
# Low-Power Watch Mode Controller

This block is the power-mode sequencer of a small microcontroller. It follows the core through its run modes (high speed, medium speed, subactive) and takes it into one of two idle states when the sleep strobe fires. One is a light sleep, where peripherals keep their clocks. The other is a deep watch state, where only the watchdog clock keeps running. For each state the block drives separate clock enables for the CPU, the general peripherals and the watchdog. When the core gets back to a run mode, the block raises a one-cycle strobe that starts interrupt handling.

The watch state is chosen only when three control bits agree at the moment of the sleep strobe. Leaving it needs a qualified wake-up. Watchdog overflow and NMI always qualify. An IRQ line qualifies only if it is enabled and the CPU mask is clear. A key input or wake-event input qualifies under the same two conditions. The resume mode depends on the low-speed select bit and on a clock-divide-nonzero input. A resume to high speed first waits through a programmable oscillator stabilization time with all clocks except the watchdog's still gated. The reset pin and the standby pin override everything else.

Top module: `watch_mode_ctrl`

## Requirements
- R1: While rst_ni is low, mode_o is 0 (reset) and all three clock enables and irq_start_o are 0. At the first clock edge after release, with both pins low, mode_o becomes 1 (high speed) and all enables become 1.
- R2: Watch is entered (mode_o = 5) at the edge where sleep_i is 1 while mode_o is 1 or 3, with ssby_sel_i = 1, dt_dis_i = 0 and wdt_src_sel_i = 1.
- R3: Any other sleep strobe in a run mode (1 = high, 2 = medium, 3 = subactive) gives plain sleep (mode_o = 4), with cpu_clk_en_o = 0, per_clk_en_o = 1 and wdt_clk_en_o = 1. A qualified wake-up returns to the run mode that was left.
- R4: In watch (5), cpu_clk_en_o = 0, per_clk_en_o = 0 and wdt_clk_en_o = 1. The block stays in watch while no qualified wake-up is present.
- R5: A wake-up qualifies if any of these holds: wdt_ovf_i or nmi_i is 1; some irq_i bit and its irq_en_i bit are both 1 while cpu_mask_i = 0; some key_i or wue_i bit and its enable bit are both 1 while cpu_mask_i = 0.
- R6: A qualified wake-up in watch with low_speed_sel_i = 1 moves to subactive (3) at the next edge, with irq_start_o = 1 in that cycle.
- R7: With low_speed_sel_i = 0, a wake-up in watch moves to medium speed (2), with irq_start_o = 1, if clk_div_nz_i = 1. If clk_div_nz_i = 0, it moves to stabilization (6).
- R8: Stabilization lasts exactly 2^(8+n) cycles, where n is stab_sel_i sampled at wake-up. Clock enables are the same as in watch. The block then enters high speed (1) with irq_start_o = 1.
- R9: res_pin_i = 1 forces mode_o = 0 at the next edge from any mode, and holds it there.
- R10: stby_pin_i = 1 with res_pin_i = 0 forces hardware standby (mode_o = 7, all enables 0) at the next edge, ahead of any wake-up. Its release leads to reset (0) and then to high speed.
- R11: irq_start_o is a one-cycle pulse, raised only in the first cycle of a resume from sleep, watch or stabilization.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sleep_i | input | 1 | Sleep instruction strobe |
| ssby_sel_i | input | 1 | Standby select bit |
| dt_dis_i | input | 1 | Direct-transition bit, must be 0 for watch |
| wdt_src_sel_i | input | 1 | Watchdog clock-source select bit |
| low_speed_sel_i | input | 1 | Resume to subactive when 1 |
| clk_div_nz_i | input | 1 | Resume to medium speed when 1 |
| stab_sel_i | input | 3 | Stabilization time select n |
| wdt_ovf_i | input | 1 | Watchdog overflow |
| nmi_i | input | 1 | Non-maskable interrupt |
| irq_i | input | 16 | IRQ lines |
| irq_en_i | input | 16 | IRQ enables |
| key_i | input | 10 | Key inputs |
| key_en_i | input | 10 | Key input enables |
| wue_i | input | 8 | Wake-up event inputs |
| wue_en_i | input | 8 | Wake-up event enables |
| cpu_mask_i | input | 1 | CPU interrupt mask |
| res_pin_i | input | 1 | Reset pin, active high |
| stby_pin_i | input | 1 | Standby pin, active high |
| mode_o | output | 3 | Current mode code |
| cpu_clk_en_o | output | 1 | CPU clock enable |
| per_clk_en_o | output | 1 | Peripheral clock enable |
| wdt_clk_en_o | output | 1 | Watchdog clock enable |
| irq_start_o | output | 1 | Interrupt handling start strobe |

## Verification
Wake qualification is driven with random mixes of IRQ, key and wake-event bits, enables, the CPU mask and sparse NMI and overflow pulses. A bench model predicts whether each mix ends watch, so a missing enable or mask term in any group shows up as a wrong stay-or-leave decision. Directed sequences then take each resume path (subactive, medium, and high speed through two stabilization lengths) and count the stabilization cycles exactly. Further sequences enter plain sleep from high and medium speed, which separates the three-bit entry rule from the mode condition. The last group asserts the pins during watch and stabilization, where they must win over a wake-up that arrives at the same time.

// File: rtl/wmc_pkg.sv
package wmc_pkg;
  typedef enum logic [2:0] {
    MODE_RESET = 3'd0,
    MODE_HIGH  = 3'd1,
    MODE_MED   = 3'd2,
    MODE_SUB   = 3'd3,
    MODE_SLEEP = 3'd4,
    MODE_WATCH = 3'd5,
    MODE_STAB  = 3'd6,
    MODE_HSTBY = 3'd7
  } mode_e;
endpackage

// File: rtl/wmc_src_gate.sv
module wmc_src_gate #(
  parameter int W = 8
) (
  input  logic [W-1:0] src_i,
  input  logic [W-1:0] en_i,
  input  logic         mask_i,
  output logic         hit_o
);
  assign hit_o = (|(src_i & en_i)) & ~mask_i;
endmodule

// File: rtl/wmc_wake_qual.sv
module wmc_wake_qual #(
  parameter int N_IRQ = 16,
  parameter int N_KEY = 10,
  parameter int N_WUE = 8
) (
  input  logic             wdt_ovf_i,
  input  logic             nmi_i,
  input  logic [N_IRQ-1:0] irq_i,
  input  logic [N_IRQ-1:0] irq_en_i,
  input  logic [N_KEY-1:0] key_i,
  input  logic [N_KEY-1:0] key_en_i,
  input  logic [N_WUE-1:0] wue_i,
  input  logic [N_WUE-1:0] wue_en_i,
  input  logic             cpu_mask_i,
  output logic             wake_o
);
  logic irq_hit, key_hit, wue_hit;

  wmc_src_gate #(.W(N_IRQ)) u_irq (
    .src_i(irq_i), .en_i(irq_en_i), .mask_i(cpu_mask_i), .hit_o(irq_hit));
  wmc_src_gate #(.W(N_KEY)) u_key (
    .src_i(key_i), .en_i(key_en_i), .mask_i(cpu_mask_i), .hit_o(key_hit));
  wmc_src_gate #(.W(N_WUE)) u_wue (
    .src_i(wue_i), .en_i(wue_en_i), .mask_i(cpu_mask_i), .hit_o(wue_hit));

  // unmaskable sources first
  assign wake_o = wdt_ovf_i | nmi_i | irq_hit | key_hit | wue_hit;
endmodule

// File: rtl/wmc_stab_timer.sv
module wmc_stab_timer #(
  parameter int BASE_LOG2 = 8,
  parameter int SEL_W     = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic             run_i,
  input  logic [SEL_W-1:0] sel_i,
  output logic             done_o
);
  localparam int CW = BASE_LOG2 + (1 << SEL_W);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] load_val;

  assign load_val = ({{(CW-1){1'b0}}, 1'b1} << (BASE_LOG2 + int'(sel_i))) - {{(CW-1){1'b0}}, 1'b1};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                      cnt_q <= '0;
    else if (load_i)                  cnt_q <= load_val;
    else if (run_i && cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
  end

  assign done_o = run_i && (cnt_q == '0);
endmodule

// File: rtl/wmc_fsm.sv
module wmc_fsm
  import wmc_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  sleep_i,
  input  logic  ssby_sel_i,
  input  logic  dt_dis_i,
  input  logic  wdt_src_sel_i,
  input  logic  low_speed_sel_i,
  input  logic  clk_div_nz_i,
  input  logic  wake_i,
  input  logic  res_pin_i,
  input  logic  stby_pin_i,
  input  logic  stab_done_i,
  output mode_e mode_o,
  output logic  stab_load_o,
  output logic  irq_start_o
);
  mode_e st_q, st_d, ret_q, ret_d;
  logic  start_d, start_q;
  logic  watch_ok;

  assign watch_ok = ssby_sel_i & ~dt_dis_i & wdt_src_sel_i;

  always_comb begin
    st_d        = st_q;
    ret_d       = ret_q;
    start_d     = 1'b0;
    stab_load_o = 1'b0;
    if (res_pin_i)       st_d = MODE_RESET;
    else if (stby_pin_i) st_d = MODE_HSTBY;
    else begin
      unique case (st_q)
        MODE_RESET: st_d = MODE_HIGH;
        MODE_HSTBY: st_d = MODE_RESET;
        MODE_HIGH, MODE_MED, MODE_SUB: begin
          if (sleep_i) begin
            if (st_q != MODE_MED && watch_ok) st_d = MODE_WATCH;
            else begin
              st_d  = MODE_SLEEP;
              ret_d = st_q;
            end
          end
        end
        MODE_SLEEP: begin
          if (wake_i) begin
            st_d    = ret_q;
            start_d = 1'b1;
          end
        end
        MODE_WATCH: begin
          if (wake_i) begin
            if (low_speed_sel_i) begin
              st_d    = MODE_SUB;
              start_d = 1'b1;
            end else if (clk_div_nz_i) begin
              st_d    = MODE_MED;
              start_d = 1'b1;
            end else begin
              st_d        = MODE_STAB;
              stab_load_o = 1'b1;
            end
          end
        end
        MODE_STAB: begin
          if (stab_done_i) begin
            st_d    = MODE_HIGH;
            start_d = 1'b1;
          end
        end
        default: st_d = MODE_RESET;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= MODE_RESET;
      ret_q   <= MODE_HIGH;
      start_q <= 1'b0;
    end else begin
      st_q    <= st_d;
      ret_q   <= ret_d;
      start_q <= start_d;
    end
  end

  assign mode_o      = st_q;
  assign irq_start_o = start_q;
endmodule

// File: rtl/watch_mode_ctrl.sv
module watch_mode_ctrl
  import wmc_pkg::*;
#(
  parameter int N_IRQ     = 16,
  parameter int N_KEY     = 10,
  parameter int N_WUE     = 8,
  parameter int STAB_SEL_W = 3,
  parameter int STAB_BASE  = 8
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  sleep_i,
  input  logic                  ssby_sel_i,
  input  logic                  dt_dis_i,
  input  logic                  wdt_src_sel_i,
  input  logic                  low_speed_sel_i,
  input  logic                  clk_div_nz_i,
  input  logic [STAB_SEL_W-1:0] stab_sel_i,
  input  logic                  wdt_ovf_i,
  input  logic                  nmi_i,
  input  logic [N_IRQ-1:0]      irq_i,
  input  logic [N_IRQ-1:0]      irq_en_i,
  input  logic [N_KEY-1:0]      key_i,
  input  logic [N_KEY-1:0]      key_en_i,
  input  logic [N_WUE-1:0]      wue_i,
  input  logic [N_WUE-1:0]      wue_en_i,
  input  logic                  cpu_mask_i,
  input  logic                  res_pin_i,
  input  logic                  stby_pin_i,
  output logic [2:0]            mode_o,
  output logic                  cpu_clk_en_o,
  output logic                  per_clk_en_o,
  output logic                  wdt_clk_en_o,
  output logic                  irq_start_o
);
  logic  wake, stab_load, stab_done;
  mode_e mode;

  wmc_wake_qual #(.N_IRQ(N_IRQ), .N_KEY(N_KEY), .N_WUE(N_WUE)) u_wake (
    .wdt_ovf_i (wdt_ovf_i),
    .nmi_i     (nmi_i),
    .irq_i     (irq_i),
    .irq_en_i  (irq_en_i),
    .key_i     (key_i),
    .key_en_i  (key_en_i),
    .wue_i     (wue_i),
    .wue_en_i  (wue_en_i),
    .cpu_mask_i(cpu_mask_i),
    .wake_o    (wake)
  );

  wmc_stab_timer #(.BASE_LOG2(STAB_BASE), .SEL_W(STAB_SEL_W)) u_stab (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .load_i(stab_load),
    .run_i (mode == MODE_STAB),
    .sel_i (stab_sel_i),
    .done_o(stab_done)
  );

  wmc_fsm u_fsm (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .sleep_i        (sleep_i),
    .ssby_sel_i     (ssby_sel_i),
    .dt_dis_i       (dt_dis_i),
    .wdt_src_sel_i  (wdt_src_sel_i),
    .low_speed_sel_i(low_speed_sel_i),
    .clk_div_nz_i   (clk_div_nz_i),
    .wake_i         (wake),
    .res_pin_i      (res_pin_i),
    .stby_pin_i     (stby_pin_i),
    .stab_done_i    (stab_done),
    .mode_o         (mode),
    .stab_load_o    (stab_load),
    .irq_start_o    (irq_start_o)
  );

  // clock gating per mode: {cpu, per, wdt}
  logic [2:0] gate;
  always_comb begin
    unique case (mode)
      MODE_HIGH, MODE_MED, MODE_SUB: gate = 3'b111;
      MODE_SLEEP:                    gate = 3'b011;
      MODE_WATCH, MODE_STAB:         gate = 3'b001;
      default:                       gate = 3'b000;
    endcase
  end

  assign {cpu_clk_en_o, per_clk_en_o, wdt_clk_en_o} = gate;
  assign mode_o = mode;
endmodule

// File: rtl/wmc_checker.sv
module wmc_checker
  import wmc_pkg::*;
#(
  parameter int N_IRQ = 16,
  parameter int N_KEY = 10,
  parameter int N_WUE = 8
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             sleep_i,
  input logic             ssby_sel_i,
  input logic             dt_dis_i,
  input logic             wdt_src_sel_i,
  input logic             low_speed_sel_i,
  input logic             wdt_ovf_i,
  input logic             nmi_i,
  input logic [N_IRQ-1:0] irq_en_i,
  input logic [N_KEY-1:0] key_en_i,
  input logic [N_WUE-1:0] wue_en_i,
  input logic             res_pin_i,
  input logic             stby_pin_i,
  input logic [2:0]       mode_o,
  input logic             cpu_clk_en_o,
  input logic             per_clk_en_o,
  input logic             wdt_clk_en_o,
  input logic             irq_start_o
);
  logic pins_idle;
  assign pins_idle = !res_pin_i && !stby_pin_i;

  p_reset_clocks_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_o == MODE_RESET |-> !cpu_clk_en_o && !per_clk_en_o && !wdt_clk_en_o);

  p_watch_entry_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_o == MODE_HIGH && sleep_i && ssby_sel_i && !dt_dis_i && wdt_src_sel_i && pins_idle)
    |=> mode_o == MODE_WATCH);

  p_sleep_clocks_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_o == MODE_SLEEP |-> !cpu_clk_en_o && per_clk_en_o && wdt_clk_en_o);

  p_watch_clocks_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_o == MODE_WATCH |-> !cpu_clk_en_o && !per_clk_en_o && wdt_clk_en_o);

  p_watch_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_o == MODE_WATCH && !nmi_i && !wdt_ovf_i && irq_en_i == '0 &&
     key_en_i == '0 && wue_en_i == '0 && pins_idle) |=> mode_o == MODE_WATCH);

  p_resume_sub_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_o == MODE_WATCH && nmi_i && low_speed_sel_i && pins_idle)
    |=> mode_o == MODE_SUB && irq_start_o);

  p_stab_clocks_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_o == MODE_STAB |-> !cpu_clk_en_o && !per_clk_en_o && wdt_clk_en_o);

  p_reset_pin_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    res_pin_i |=> mode_o == MODE_RESET);

  p_stby_pin_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stby_pin_i && !res_pin_i) |=> mode_o == MODE_HSTBY && !wdt_clk_en_o);

  p_start_pulse_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_start_o |=> !irq_start_o);
endmodule

bind watch_mode_ctrl wmc_checker #(.N_IRQ(N_IRQ), .N_KEY(N_KEY), .N_WUE(N_WUE)) u_wmc_checker (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .sleep_i        (sleep_i),
  .ssby_sel_i     (ssby_sel_i),
  .dt_dis_i       (dt_dis_i),
  .wdt_src_sel_i  (wdt_src_sel_i),
  .low_speed_sel_i(low_speed_sel_i),
  .wdt_ovf_i      (wdt_ovf_i),
  .nmi_i          (nmi_i),
  .irq_en_i       (irq_en_i),
  .key_en_i       (key_en_i),
  .wue_en_i       (wue_en_i),
  .res_pin_i      (res_pin_i),
  .stby_pin_i     (stby_pin_i),
  .mode_o         (mode_o),
  .cpu_clk_en_o   (cpu_clk_en_o),
  .per_clk_en_o   (per_clk_en_o),
  .wdt_clk_en_o   (wdt_clk_en_o),
  .irq_start_o    (irq_start_o)
);

// File: tb/watch_mode_ctrl_bench.sv
`timescale 1ns/1ps
module watch_mode_ctrl_bench;
  logic        clk_i = 1'b0;
  logic        rst_ni;
  logic        sleep_i, ssby_sel_i, dt_dis_i, wdt_src_sel_i;
  logic        low_speed_sel_i, clk_div_nz_i;
  logic [2:0]  stab_sel_i;
  logic        wdt_ovf_i, nmi_i, cpu_mask_i, res_pin_i, stby_pin_i;
  logic [15:0] irq_i, irq_en_i;
  logic [9:0]  key_i, key_en_i;
  logic [7:0]  wue_i, wue_en_i;
  logic [2:0]  mode_o;
  logic        cpu_clk_en_o, per_clk_en_o, wdt_clk_en_o, irq_start_o;

  int n_chk  = 0;
  int n_fail = 0;

  always #2.5 clk_i = ~clk_i;

  watch_mode_ctrl u_watch_mode_ctrl (.*);

  function automatic logic exp_wake(logic nmi, logic ovf, logic [15:0] irq, logic [15:0] ie,
                                    logic [9:0] k, logic [9:0] ke, logic [7:0] w,
                                    logic [7:0] we, logic msk);
    logic any_irq, any_key, any_wue;
    any_irq = 1'b0; any_key = 1'b0; any_wue = 1'b0;
    for (int i = 0; i < 16; i++) if (irq[i] && ie[i]) any_irq = 1'b1;
    for (int i = 0; i < 10; i++) if (k[i] && ke[i]) any_key = 1'b1;
    for (int i = 0; i < 8; i++)  if (w[i] && we[i]) any_wue = 1'b1;
    return nmi || ovf || (!msk && (any_irq || any_key || any_wue));
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  task automatic clear_src();
    wdt_ovf_i = 0; nmi_i = 0; cpu_mask_i = 0;
    irq_i = '0; irq_en_i = '0; key_i = '0; key_en_i = '0; wue_i = '0; wue_en_i = '0;
  endtask

  task automatic tick();
    @(negedge clk_i);
  endtask

  task automatic go_high();
    res_pin_i = 1; tick();
    check("R9 reset pin", {29'd0, mode_o}, 32'd0);
    res_pin_i = 0; tick();
    check("R1 high after reset", {29'd0, mode_o}, 32'd1);
  endtask

  task automatic enter_watch();
    ssby_sel_i = 1; dt_dis_i = 0; wdt_src_sel_i = 1; sleep_i = 1; tick();
    sleep_i = 0;
    check("R2 watch entry", {29'd0, mode_o}, 32'd5);
    check("R4 watch clocks", {29'd0, cpu_clk_en_o, per_clk_en_o, wdt_clk_en_o}, 32'b001);
  endtask

  task automatic stab_run(logic [2:0] n);
    int cnt;
    stab_sel_i = n; low_speed_sel_i = 0; clk_div_nz_i = 0;
    enter_watch();
    nmi_i = 1; tick(); nmi_i = 0;
    check("R7 to stabilization", {29'd0, mode_o}, 32'd6);
    cnt = 0;
    while (mode_o == 3'd6 && cnt < 40000) begin
      if ({cpu_clk_en_o, per_clk_en_o, wdt_clk_en_o} != 3'b001) begin
        check("R8 stab clocks", {29'd0, cpu_clk_en_o, per_clk_en_o, wdt_clk_en_o}, 32'b001);
      end
      cnt++; tick();
    end
    check("R8 stab length", cnt, 32'd1 << (8 + n));
    check("R8 high after stab", {29'd0, mode_o}, 32'd1);
    check("R11 start after stab", {31'd0, irq_start_o}, 32'd1);
    tick();
    check("R11 start single", {31'd0, irq_start_o}, 32'd0);
  endtask

  initial begin
    repeat (150000) @(posedge clk_i);
    n_fail++;
    $display("FAIL watchdog: run did not complete");
    finish_run();
  end

  initial begin
    int unsigned seed;
    logic w;
    seed = $urandom(32'd20240611);
    rst_ni = 0; sleep_i = 0; ssby_sel_i = 0; dt_dis_i = 0; wdt_src_sel_i = 0;
    low_speed_sel_i = 0; clk_div_nz_i = 0; stab_sel_i = 0;
    res_pin_i = 0; stby_pin_i = 0;
    clear_src();
    tick(); tick();
    check("R1 reset mode", {29'd0, mode_o}, 32'd0);
    check("R1 reset clocks", {28'd0, cpu_clk_en_o, per_clk_en_o, wdt_clk_en_o, irq_start_o}, 32'd0);
    rst_ni = 1; tick();
    check("R1 first mode", {29'd0, mode_o}, 32'd1);
    check("R1 run clocks", {29'd0, cpu_clk_en_o, per_clk_en_o, wdt_clk_en_o}, 32'b111);

    // R3: plain sleep from high (standby select clear), masked IRQ ignored
    ssby_sel_i = 0; wdt_src_sel_i = 1; sleep_i = 1; tick(); sleep_i = 0;
    check("R3 plain sleep", {29'd0, mode_o}, 32'd4);
    check("R3 sleep clocks", {29'd0, cpu_clk_en_o, per_clk_en_o, wdt_clk_en_o}, 32'b011);
    irq_i = 16'h0010; irq_en_i = 16'h0010; cpu_mask_i = 1; tick(); clear_src();
    check("R5 masked irq ignored", {29'd0, mode_o}, 32'd4);
    nmi_i = 1; tick(); nmi_i = 0;
    check("R3 resume high", {29'd0, mode_o}, 32'd1);
    check("R11 start on sleep resume", {31'd0, irq_start_o}, 32'd1);
    tick();
    check("R11 start one cycle", {31'd0, irq_start_o}, 32'd0);

    // R7 medium resume, then R3 sleep from medium even with watch bits
    low_speed_sel_i = 0; clk_div_nz_i = 1;
    enter_watch();
    key_i = 10'h200; key_en_i = 10'h200; tick(); clear_src();
    check("R7 resume medium", {29'd0, mode_o}, 32'd2);
    check("R7 start medium", {31'd0, irq_start_o}, 32'd1);
    sleep_i = 1; tick(); sleep_i = 0;
    check("R3 medium goes sleep", {29'd0, mode_o}, 32'd4);
    wdt_ovf_i = 1; tick(); clear_src();
    check("R3 return medium", {29'd0, mode_o}, 32'd2);
    go_high();

    // R6 subactive resume, then R2 watch entry from subactive
    low_speed_sel_i = 1;
    enter_watch();
    wue_i = 8'h01; wue_en_i = 8'h00; tick(); clear_src();
    check("R5 disabled wue ignored", {29'd0, mode_o}, 32'd5);
    wue_i = 8'h81; wue_en_i = 8'h80; tick(); clear_src();
    check("R6 resume sub", {29'd0, mode_o}, 32'd3);
    check("R6 start sub", {31'd0, irq_start_o}, 32'd1);
    enter_watch();
    nmi_i = 1; tick(); clear_src();
    check("R6 second sub", {29'd0, mode_o}, 32'd3);
    go_high();

    // R8 stabilization lengths
    stab_run(3'd0);
    stab_run(3'd2);

    // R10 standby wins over simultaneous wake
    low_speed_sel_i = 1;
    enter_watch();
    stby_pin_i = 1; nmi_i = 1; tick(); clear_src();
    check("R10 hw standby", {29'd0, mode_o}, 32'd7);
    check("R10 clocks off", {29'd0, cpu_clk_en_o, per_clk_en_o, wdt_clk_en_o}, 32'd0);
    tick();
    check("R10 standby held", {29'd0, mode_o}, 32'd7);
    stby_pin_i = 0; tick();
    check("R10 release to reset", {29'd0, mode_o}, 32'd0);
    tick();
    check("R10 then high", {29'd0, mode_o}, 32'd1);

    // R9 reset pin during stabilization
    low_speed_sel_i = 0; clk_div_nz_i = 0; stab_sel_i = 3'd1;
    enter_watch();
    nmi_i = 1; tick(); clear_src();
    repeat (5) tick();
    res_pin_i = 1; tick();
    check("R9 reset in stab", {29'd0, mode_o}, 32'd0);
    tick();
    check("R9 reset held", {29'd0, mode_o}, 32'd0);
    res_pin_i = 0; tick();

    // R5 random wake qualification
    low_speed_sel_i = 1;
    for (int t = 0; t < 60; t++) begin
      enter_watch();
      irq_i    = 16'($urandom & $urandom);
      irq_en_i = 16'($urandom & $urandom & $urandom);
      key_i    = 10'($urandom & $urandom);
      key_en_i = 10'($urandom & $urandom & $urandom);
      wue_i    = 8'($urandom & $urandom);
      wue_en_i = 8'($urandom & $urandom & $urandom);
      cpu_mask_i = ($urandom % 3) == 0;
      nmi_i      = ($urandom % 10) == 0;
      wdt_ovf_i  = ($urandom % 10) == 0;
      if (t == 0) begin
        irq_i = '1; irq_en_i = '1; key_i = '1; key_en_i = '1; wue_i = '1; wue_en_i = '1;
        cpu_mask_i = 1; nmi_i = 0; wdt_ovf_i = 0;
      end
      w = exp_wake(nmi_i, wdt_ovf_i, irq_i, irq_en_i, key_i, key_en_i, wue_i, wue_en_i, cpu_mask_i);
      tick(); clear_src();
      check("R5 wake decision", {29'd0, mode_o}, w ? 32'd3 : 32'd5);
      check("R11 start matches wake", {31'd0, irq_start_o}, {31'd0, w});
      go_high();
    end

    finish_run();
  end
endmodule